// File: doc/BRIEF.md
# Contactless Receive Frame Assembler

The block sits between the bit decoder of a contactless-card reader and its receive FIFO. The decoder supplies one strobe per decoded bit, the bit value, a flag for a bit in which two cards answered at once, and parity, CRC and framing verdicts. The block packs the bits into bytes, least significant bit first, and writes them to the FIFO. A 3-bit alignment input sets the bit position in the first byte where the first received bit is stored. This is used for bit-oriented anticollision frames.

Collided bits are replaced by a configurable value. Optionally, every later bit of the frame is stored as zero. The first collision position is recorded, counted from the first stored bit. A frame with an error that spans at most three bytes is treated as electromagnetic disturbance: it is discarded silently and a sticky flag is set. To allow this, the first three bytes of every frame wait in a small staging queue until the frame is known to be longer or clean. At the end of an accepted frame, status bits are loaded and an interrupt flag is raised once the last byte has been written.

Top module: `rx_frame_assembler`

## Requirements
- R1: Received bits are packed least significant bit first. The first bit of a frame is stored at bit position `cfg_align` of the first byte, and lower positions of that byte read 0. Every completed byte of an accepted frame appears once on `fifo_data` with `fifo_wr` high, in arrival order. Bit strobes outside a frame have no effect.
- R2: After an accepted frame, `last_bits` equals (cfg_align + number of bits) mod 8. The value 0 means the final byte is complete.
- R3: A bit strobed with `bit_coll` high is stored as `cfg_coll_val`, whatever its received value.
- R4: When `cfg_zero_after` is 1, every bit after the first collided bit of the frame is stored as 0. Later collided bits are still stored as `cfg_coll_val`.
- R5: `coll_pos` holds the index of the first collided bit, counting from 0 at the first stored bit. Later collisions do not change it. `stat_coll` is 1 after an accepted frame that had a collision.
- R6: A frame spanning more than 3 bytes, counting a final partial byte, is never discarded. Its first four bytes are written as soon as the fourth byte completes, before the frame ends.
- R7: An error-free frame of at most 3 bytes is written in full after the frame end, including an empty frame, which writes nothing but still raises the interrupt flag.
- R8: A frame of at most 3 bytes that ends with a CRC, framing or parity error writes nothing and loads no status bit or interrupt flag. It sets `emd_det`, which stays 1 until reset.
- R9: `rx_irq_flag` rises in the cycle after the last FIFO write of an accepted frame. It is cleared by the next `frame_start`. `rx_irq` equals the flag only while `cfg_irq_en` is 1.
- R10: `stat_crc`, `stat_frm` and `stat_par` reflect the error inputs of the last accepted frame. A parity error anywhere in the frame counts. All three are cleared at `frame_start`.
- R11: After reset, `fifo_wr`, all status bits, `last_bits`, `coll_pos`, `emd_det`, `rx_irq_flag` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_align | input | 3 | Bit position of the first stored bit in the first byte |
| cfg_coll_val | input | 1 | Value stored for a collided bit |
| cfg_zero_after | input | 1 | Store zero for all bits after the first collision |
| cfg_irq_en | input | 1 | Interrupt output enable |
| frame_start | input | 1 | Start-of-frame strobe |
| frame_end | input | 1 | End-of-frame strobe, samples crc_err and frm_err |
| bit_vld | input | 1 | Decoded bit strobe |
| bit_val | input | 1 | Decoded bit value |
| bit_coll | input | 1 | Current bit is a collision |
| par_err | input | 1 | Parity error strobe during the frame |
| crc_err | input | 1 | CRC verdict, valid with frame_end |
| frm_err | input | 1 | Framing verdict, valid with frame_end |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| stat_crc | output | 1 | CRC error of last accepted frame |
| stat_frm | output | 1 | Framing error of last accepted frame |
| stat_par | output | 1 | Parity error of last accepted frame |
| stat_coll | output | 1 | Collision in last accepted frame |
| coll_pos | output | 8 | Index of the first collided bit |
| last_bits | output | 3 | Valid bits in the final byte, 0 means all 8 |
| emd_det | output | 1 | Sticky disturbance-suppressed flag |
| rx_irq_flag | output | 1 | End-of-reception request flag |
| rx_irq | output | 1 | Gated interrupt output |

## Verification
When the frame-end strobe is sampled at a clock edge, the first held byte is on `fifo_data` right after that edge. One more byte follows per cycle. `rx_irq_flag` follows one cycle after the last write. For a long frame, the four held bytes leave on the four cycles after the edge that takes the eighth bit of the fourth byte. The bench drives and samples on the falling edge. It checks this timing cycle by cycle in one directed test. In the other tests it records every write with a falling-edge monitor and compares the byte list, status and flags after a settling gap longer than the deepest drain.

// File: rtl/rxp_pkg.sv
// Package rxp_pkg
// Shared constants and types for the receive frame assembler.
// Assumes byte-wide FIFO data.
package rxp_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = $clog2(BYTE_W);

    // per-frame error summary loaded at an accepted frame end
    typedef struct packed {
        logic crc;
        logic frm;
        logic par;
        logic coll;
    } rx_stat_t;
endpackage

// File: rtl/rxp_coll_shaper.sv
// Module rxp_coll_shaper
// Substitutes collided bits, zero-fills after the first collision when
// enabled, and records the index of the first collision.
// Assumes bit_vld is already gated to the inside of a frame.
module rxp_coll_shaper #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             coll_in,
    input  logic             coll_val,
    input  logic             zero_after,
    output logic             bit_out,
    output logic             coll_seen,
    output logic [POS_W-1:0] coll_pos
);
    logic [POS_W-1:0] bit_cnt;
    logic             zfill;

    // choose the stored bit value
    always_comb begin
        if (coll_in)    bit_out = coll_val;
        else if (zfill) bit_out = 1'b0;
        else            bit_out = bit_in;
    end

    // count stored bits and capture the first collision
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            bit_cnt   <= '0;
            zfill     <= 1'b0;
            coll_seen <= 1'b0;
            coll_pos  <= '0;
        end else if (bit_vld) begin
            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
            if (coll_in && !coll_seen) begin
                coll_seen <= 1'b1;
                coll_pos  <= bit_cnt;
                if (zero_after) zfill <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxp_byte_builder.sv
// Module rxp_byte_builder
// Packs bits LSB first into a byte, starting at a programmable position.
// Assumes at most one bit per cycle.
module rxp_byte_builder
    import rxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  align,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_data,
    output logic [BYTE_W-1:0] part_data,
    output logic              part,
    output logic [PTR_W-1:0]  ptr
);
    logic [BYTE_W-1:0] acc;

    // merge the incoming bit into the accumulator
    always_comb begin
        byte_data = acc | ({{(BYTE_W-1){1'b0}}, bit_in} << ptr);
        byte_done = bit_vld && (ptr == PTR_W'(BYTE_W - 1));
        part_data = acc;
    end

    // advance the bit pointer and hold partial bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            ptr  <= '0;
            part <= 1'b0;
        end else if (start) begin
            acc  <= '0;
            ptr  <= align;
            part <= 1'b0;
        end else if (bit_vld) begin
            if (byte_done) begin
                acc  <= '0;
                ptr  <= '0;
                part <= 1'b0;
            end else begin
                acc  <= byte_data;
                ptr  <= ptr + 1'b1;
                part <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxp_stage_queue.sv
// Module rxp_stage_queue
// Holds bytes of a frame until released, then writes them one per cycle.
// Assumes pushes during a drain never exceed DEPTH held entries.
module rxp_stage_queue #(
    parameter int DEPTH = 5,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         flush,
    input  logic         drop,
    output logic         wr_en,
    output logic [W-1:0] wr_data,
    output logic         busy
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;
    logic [IDX_W-1:0] rd;
    logic             draining;

    // entries after this cycle's push
    always_comb cnt_n = cnt + CNT_W'(push);

    // store a pushed byte
    always_ff @(posedge clk) begin
        if (push) mem[cnt[IDX_W-1:0]] <= push_data;
    end

    // hold, drop or drain the queued bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            rd       <= '0;
            draining <= 1'b0;
        end else if (drop && !draining) begin
            cnt <= '0;
        end else if (draining) begin
            if (CNT_W'(rd) == cnt_n - 1'b1) begin
                draining <= 1'b0;
                cnt      <= '0;
                rd       <= '0;
            end else begin
                rd  <= rd + 1'b1;
                cnt <= cnt_n;
            end
        end else begin
            cnt <= cnt_n;
            if (flush && cnt_n != '0) begin
                draining <= 1'b1;
                rd       <= '0;
            end
        end
    end

    assign wr_en   = draining;
    assign wr_data = mem[rd];
    assign busy    = draining;
endmodule

// File: rtl/rx_frame_assembler.sv
// Module rx_frame_assembler
// Assembles decoded contactless bits into FIFO bytes. It applies collision
// substitution and discards short erroneous frames as disturbance.
// Assumes: frame_start and frame_end never coincide with bit_vld, and the
// gap between frames is longer than the drain of the staged bytes.
module rx_frame_assembler
    import rxp_pkg::*;
#(
    parameter int HOLD_BYTES = 3,
    parameter int POS_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  cfg_align,
    input  logic              cfg_coll_val,
    input  logic              cfg_zero_after,
    input  logic              cfg_irq_en,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              bit_coll,
    input  logic              par_err,
    input  logic              crc_err,
    input  logic              frm_err,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              stat_crc,
    output logic              stat_frm,
    output logic              stat_par,
    output logic              stat_coll,
    output logic [POS_W-1:0]  coll_pos,
    output logic [PTR_W-1:0]  last_bits,
    output logic              emd_det,
    output logic              rx_irq_flag,
    output logic              rx_irq
);
    localparam int QDEPTH = HOLD_BYTES + 2;
    localparam int BC_W   = $clog2(HOLD_BYTES + 2);

    logic              active, take_bit, at_end;
    logic              shaped_bit, coll_seen;
    logic              byte_done, part;
    logic [BYTE_W-1:0] byte_data, part_data;
    logic [PTR_W-1:0]  ptr;
    logic [BC_W-1:0]   byte_cnt;
    logic [BC_W:0]     span;
    logic              is_long, is_short, frame_bad, drop_frame;
    logic              q_push, q_flush, q_drop, q_busy;
    logic [BYTE_W-1:0] q_data;
    logic              par_seen, irq_pend;
    rx_stat_t          stat;

    // qualify strobes with the in-frame state
    always_comb begin
        take_bit   = bit_vld && active;
        at_end     = frame_end && active;
        is_long    = byte_cnt > BC_W'(HOLD_BYTES);
        span       = {1'b0, byte_cnt} + {{BC_W{1'b0}}, part};
        is_short   = !is_long && (span <= (BC_W+1)'(HOLD_BYTES));
        frame_bad  = crc_err || frm_err || par_seen || par_err;
        drop_frame = at_end && is_short && frame_bad;
    end

    // steer bytes into the staging queue and release them
    always_comb begin
        q_push  = (take_bit && byte_done) || (at_end && part && !drop_frame);
        q_data  = take_bit ? byte_data : part_data;
        q_flush = (take_bit && byte_done && byte_cnt >= BC_W'(HOLD_BYTES))
                  || (at_end && !drop_frame);
        q_drop  = drop_frame || frame_start;
    end

    rxp_coll_shaper #(.POS_W(POS_W)) u_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (frame_start),
        .bit_vld    (take_bit),
        .bit_in     (bit_val),
        .coll_in    (bit_coll),
        .coll_val   (cfg_coll_val),
        .zero_after (cfg_zero_after),
        .bit_out    (shaped_bit),
        .coll_seen  (coll_seen),
        .coll_pos   (coll_pos)
    );

    rxp_byte_builder u_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_start),
        .align     (cfg_align),
        .bit_vld   (take_bit),
        .bit_in    (shaped_bit),
        .byte_done (byte_done),
        .byte_data (byte_data),
        .part_data (part_data),
        .part      (part),
        .ptr       (ptr)
    );

    rxp_stage_queue #(.DEPTH(QDEPTH), .W(BYTE_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_data),
        .flush     (q_flush),
        .drop      (q_drop),
        .wr_en     (fifo_wr),
        .wr_data   (fifo_data),
        .busy      (q_busy)
    );

    // frame state, byte count, status, disturbance flag and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active      <= 1'b0;
            byte_cnt    <= '0;
            par_seen    <= 1'b0;
            stat        <= '0;
            last_bits   <= '0;
            emd_det     <= 1'b0;
            irq_pend    <= 1'b0;
            rx_irq_flag <= 1'b0;
        end else if (frame_start) begin
            active      <= 1'b1;
            byte_cnt    <= '0;
            par_seen    <= 1'b0;
            stat        <= '0;
            last_bits   <= '0;
            irq_pend    <= 1'b0;
            rx_irq_flag <= 1'b0;
        end else begin
            if (take_bit && byte_done && !is_long) byte_cnt <= byte_cnt + 1'b1;
            if (par_err && active) par_seen <= 1'b1;
            if (at_end) begin
                active <= 1'b0;
                if (drop_frame) begin
                    emd_det <= 1'b1;
                end else begin
                    stat.crc  <= crc_err;
                    stat.frm  <= frm_err;
                    stat.par  <= par_seen || par_err;
                    stat.coll <= coll_seen;
                    last_bits <= part ? ptr : '0;
                    irq_pend  <= 1'b1;
                end
            end else if (irq_pend && !q_busy) begin
                irq_pend    <= 1'b0;
                rx_irq_flag <= 1'b1;
            end
        end
    end

    assign stat_crc  = stat.crc;
    assign stat_frm  = stat.frm;
    assign stat_par  = stat.par;
    assign stat_coll = stat.coll;
    assign rx_irq    = rx_irq_flag && cfg_irq_en;
endmodule

// File: rtl/rxp_checker.sv
// Module rxp_checker
// Temporal properties of the receive frame assembler, seen at its ports.
// Assumes the clock and reset of the bound instance.
module rxp_checker #(
    parameter int POS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             fifo_wr,
    input logic             stat_crc,
    input logic             stat_coll,
    input logic [POS_W-1:0] coll_pos,
    input logic             emd_det,
    input logic             rx_irq_flag
);
    // the flag rises only after the last write of the frame
    p_irq_after_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq_flag) |-> !fifo_wr);

    // a new frame clears the request flag
    p_irq_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !rx_irq_flag);

    // disturbance flag is sticky
    p_emd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        emd_det |=> emd_det);

    // a suppressed frame loads no status and writes nothing
    p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emd_det) |-> (!rx_irq_flag && !stat_crc && !fifo_wr));

    // collision position is held after an accepted frame
    p_coll_pos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_coll && !frame_start) |=> $stable(coll_pos));
endmodule

bind rx_frame_assembler rxp_checker #(.POS_W(POS_W)) u_rxp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .fifo_wr     (fifo_wr),
    .stat_crc    (stat_crc),
    .stat_coll   (stat_coll),
    .coll_pos    (coll_pos),
    .emd_det     (emd_det),
    .rx_irq_flag (rx_irq_flag)
);

// File: tb/test_rx_frame_assembler.sv
// Bench for rx_frame_assembler: a vector table walked by one loop, then
// directed tests for reset, timing and corner cases.
module test_rx_frame_assembler;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  align;
        logic [5:0]  nbits;
        logic [39:0] data;
        logic [39:0] cmask;
        logic        cv;
        logic        zf;
        logic        crc;
        logic        frm;
        logic        par;
        logic [3:0]  exp_n;
        logic        exp_drop;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 6'd16, 40'hA55A,       40'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0},
        '{3'd0, 6'd7,  40'h26,         40'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1, 1'b0},
        '{3'd3, 6'd13, 40'h1ABC,       40'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0},
        '{3'd0, 6'd32, 40'h11223344,   40'h0,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd4, 1'b0},
        '{3'd0, 6'd16, 40'h1234,       40'h0,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd0, 1'b1},
        '{3'd0, 6'd24, 40'hABCDEF,     40'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 4'd0, 1'b1},
        '{3'd0, 6'd25, 40'h0111223344, 40'h0,  1'b0,1'b0,1'b0,1'b1,1'b0, 4'd4, 1'b0},
        '{3'd0, 6'd16, 40'hFFFF,       40'h20, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0},
        '{3'd0, 6'd16, 40'hFFFF,       40'h20, 1'b1,1'b1,1'b0,1'b0,1'b0, 4'd2, 1'b0},
        '{3'd2, 6'd14, 40'h3FFF,       40'h08, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'd2, 1'b0},
        '{3'd0, 6'd40, 40'h55AA33CC0F, 40'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5, 1'b0},
        '{3'd0, 6'd0,  40'h0,          40'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_align = '0;
    logic       cfg_coll_val = 1'b0, cfg_zero_after = 1'b0, cfg_irq_en = 1'b1;
    logic       frame_start = 1'b0, frame_end = 1'b0;
    logic       bit_vld = 1'b0, bit_val = 1'b0, bit_coll = 1'b0;
    logic       par_err = 1'b0, crc_err = 1'b0, frm_err = 1'b0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       stat_crc, stat_frm, stat_par, stat_coll;
    logic [7:0] coll_pos;
    logic [2:0] last_bits;
    logic       emd_det, rx_irq_flag, rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] cap [16];
    int cap_n = 0;
    bit done = 1'b0;

    rx_frame_assembler i_rx_frame_assembler (
        .clk(clk), .rst_n(rst_n), .cfg_align(cfg_align),
        .cfg_coll_val(cfg_coll_val), .cfg_zero_after(cfg_zero_after),
        .cfg_irq_en(cfg_irq_en), .frame_start(frame_start),
        .frame_end(frame_end), .bit_vld(bit_vld), .bit_val(bit_val),
        .bit_coll(bit_coll), .par_err(par_err), .crc_err(crc_err),
        .frm_err(frm_err), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .stat_crc(stat_crc), .stat_frm(stat_frm), .stat_par(stat_par),
        .stat_coll(stat_coll), .coll_pos(coll_pos), .last_bits(last_bits),
        .emd_det(emd_det), .rx_irq_flag(rx_irq_flag), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // record every FIFO write away from the active edge
    always @(negedge clk) begin
        if (fifo_wr && cap_n < 16) begin
            cap[cap_n] = fifo_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // stored bit stream predicted from the requirements
    function automatic logic [47:0] model(input vec_t v);
        logic [47:0] s = '0;
        logic zero = 1'b0;
        logic b;
        for (int i = 0; i < int'(v.nbits); i++) begin
            b = v.data[i];
            if (v.cmask[i]) b = v.cv;
            else if (zero) b = 1'b0;
            s[int'(v.align) + i] = b;
            if (v.cmask[i] && v.zf) zero = 1'b1;
        end
        return s;
    endfunction

    function automatic int first_one(input logic [39:0] m);
        for (int i = 0; i < 40; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic begin_frame(input vec_t v);
        @(negedge clk);
        cap_n = 0;
        cfg_align = v.align; cfg_coll_val = v.cv; cfg_zero_after = v.zf;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_bits(input vec_t v);
        for (int i = 0; i < int'(v.nbits); i++) begin
            @(negedge clk);
            bit_vld = 1'b1; bit_val = v.data[i]; bit_coll = v.cmask[i];
            par_err = v.par && (i == 3);
            @(negedge clk);
            bit_vld = 1'b0; bit_coll = 1'b0; par_err = 1'b0;
        end
    endtask

    task automatic end_frame(input vec_t v);
        @(negedge clk);
        crc_err = v.crc; frm_err = v.frm; frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0; crc_err = 1'b0; frm_err = 1'b0;
    endtask

    task automatic run_and_check(input vec_t v, input logic exp_emd);
        logic [47:0] s;
        string rb;
        begin_frame(v);
        send_bits(v);
        end_frame(v);
        repeat (12) @(negedge clk);
        s = model(v);
        rb = v.zf ? "R4" : (v.cmask != 0 ? "R3" : "R1");
        chk(v.exp_drop ? "R8" : (v.exp_n > 3 ? "R6" : "R7"), "write count", 64'(cap_n), 64'(v.exp_n));
        for (int k = 0; k < int'(v.exp_n) && k < cap_n; k++)
            chk(rb, "byte", 64'(cap[k]), 64'(s[8*k +: 8]));
        chk("R2", "last_bits", 64'(last_bits),
            v.exp_drop ? 64'd0 : 64'((int'(v.align) + int'(v.nbits)) % 8));
        chk("R10", "stat crc/frm/par", {61'd0, stat_crc, stat_frm, stat_par},
            v.exp_drop ? 64'd0 : {61'd0, v.crc, v.frm, v.par});
        chk("R5", "stat_coll", 64'(stat_coll), 64'(!v.exp_drop && v.cmask != 0));
        if (v.cmask != 0 && !v.exp_drop)
            chk("R5", "coll_pos", 64'(coll_pos), 64'(first_one(v.cmask)));
        chk("R9", "irq flag", 64'(rx_irq_flag), 64'(!v.exp_drop));
        chk("R8", "emd_det", 64'(emd_det), 64'(exp_emd));
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t d;
        logic emd_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "outputs after reset",
            {fifo_wr, stat_crc, stat_frm, stat_par, stat_coll, coll_pos,
             last_bits, emd_det, rx_irq_flag, rx_irq}, 64'd0);

        // table walk
        emd_exp = 1'b0;
        for (int i = 0; i < NV; i++) begin
            emd_exp = emd_exp | VECS[i].exp_drop;
            run_and_check(VECS[i], emd_exp);
        end

        // R8: a 3-byte parity frame alone sets the sticky flag after reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11", "emd after reset", 64'(emd_det), 64'd0);
        run_and_check(VECS[5], 1'b1);

        // R9: exact write and flag timing for 12 bits 0xABC
        d = '{3'd0, 6'd12, 40'hABC, 40'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0};
        begin_frame(d);
        send_bits(d);
        end_frame(d);
        chk("R7", "first write cycle", {55'd0, fifo_wr, fifo_data}, {55'd0, 1'b1, 8'hBC});
        @(negedge clk);
        chk("R7", "second write cycle", {55'd0, fifo_wr, fifo_data}, {55'd0, 1'b1, 8'h0A});
        @(negedge clk);
        chk("R9", "idle before flag", {62'd0, fifo_wr, rx_irq_flag}, 64'd0);
        @(negedge clk);
        chk("R9", "flag one cycle after last write", 64'(rx_irq_flag), 64'd1);

        // R9: interrupt output gated by enable, flag cleared by frame start
        cfg_irq_en = 1'b0;
        @(negedge clk);
        chk("R9", "irq masked", {62'd0, rx_irq_flag, rx_irq}, 64'd2);
        cfg_irq_en = 1'b1;
        @(negedge clk);
        chk("R9", "irq enabled", 64'(rx_irq), 64'd1);
        begin_frame(d);
        chk("R9", "flag cleared by frame start", 64'(rx_irq_flag), 64'd0);
        end_frame(d);
        repeat (4) @(negedge clk);

        // R6: four bytes leave before the frame end
        d = '{3'd0, 6'd32, 40'hDEADBEEF, 40'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4, 1'b0};
        begin_frame(d);
        send_bits(d);
        repeat (5) @(negedge clk);
        chk("R6", "early write count", 64'(cap_n), 64'd4);
        chk("R6", "early fourth byte", 64'(cap[3]), 64'hDE);
        chk("R6", "no flag before end", 64'(rx_irq_flag), 64'd0);
        end_frame(d);
        repeat (4) @(negedge clk);
        chk("R6", "flag after long frame", 64'(rx_irq_flag), 64'd1);

        // R5: only the first of two collisions is recorded
        d = '{3'd0, 6'd16, 40'hFFFF, 40'h204, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2, 1'b0};
        run_and_check(d, 1'b1);
        chk("R3", "two substituted bits", {48'd0, cap[1], cap[0]}, 64'hFDFB);

        // R1: strobes outside a frame are ignored
        repeat (3) begin
            @(negedge clk); bit_vld = 1'b1; bit_val = 1'b1; bit_coll = 1'b1;
            @(negedge clk); bit_vld = 1'b0; bit_coll = 1'b0;
        end
        @(negedge clk); frame_end = 1'b1; crc_err = 1'b1;
        @(negedge clk); frame_end = 1'b0; crc_err = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1", "no writes outside frame", 64'(cap_n), 64'd2);
        chk("R1", "status untouched outside frame", {62'd0, stat_crc, rx_irq_flag}, 64'd1);
        d = '{3'd0, 6'd8, 40'h5A, 40'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1, 1'b0};
        run_and_check(d, 1'b1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule